// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Controller

This block produces the digital frequency-offset profile that steers the fractional divider of a spread-spectrum clock synthesizer. A 5-bit spread code picks both the sweep style (below-nominal only, or symmetric about nominal) and the sweep depth. The code comes either from two configuration straps captured while reset is held or from a software-written code field. A hardware/software select input decides which source is used. An enable input switches spreading on or off.

The output is a signed offset word that traces a triangle once every `CLK_HZ/MOD_HZ` clock cycles, which places the modulation rate in the 20 to 40 kHz band. It comes with a valid strobe. The offset word is counted in units of 1/`HALF` of a part per 10,000, where `HALF` is half the period in cycles. So a depth of 1.00 % (100 parts per 10,000) reaches a magnitude of `100*HALF`.

The sweep is an up/down accumulator. It adds the depth (or twice the depth) once per clock and turns around at fixed phase points. A new code or enable is accepted only at the start of a period, where the offset is zero, so the output never jumps. An asynchronous active-low power-down request is synchronized and stops the sweep. While power-down is active the word is held at zero and the strobe is low. When the request is released, the sweep restarts from phase zero.

Top module: `ssc_profile_ctl`

## Requirements
- R1: Down-spread codes and their depth in parts per 10,000. Codes 0–6 give 80, 100, 125, 150, 175, 200, 250. Codes 12–15 give 125, 100, 150, 200. Codes 16–23 give 80, 100, 125, 150, 175, 200, 250, 300. In these modes the offset is never positive and its lowest value in a period is `-depth*HALF`.
- R2: Center-spread codes and their depth in parts per 10,000. Codes 7–11 give 60, 100, 125, 150, 200. Codes 24–31 give 30, 40, 50, 60, 80, 100, 125, 150. In these modes the offset peaks at `+depth*HALF` and `-depth*HALF`.
- R3: Step size per clock:
  - Down-spread changes the offset by exactly `depth` per valid clock.
  - Center-spread changes it by exactly `2*depth`.
  - The first sample of a period equals `-depth` (down) or `+2*depth` (center).
- R4: Period and shape:
  - One period is `P = CLK_HZ/MOD_HZ` valid clocks, with `P` a multiple of 4.
  - At count n (1..P) in the period, down-spread gives `-depth*n` for n ≤ P/2 and `-depth*(P-n)` after that.
  - Center-spread rises to its peak at n = P/4, falls to its trough at n = 3P/4, and returns to 0 at n = P.
- R5: The straps are captured on every clock while `rst_n` is low and are read back on `strap_rb`. Changes to the straps after reset do not alter `strap_rb`.
- R6: With `sw_mode`=0, latched straps 11 select code 8 (±1.00 % center). Any other strap value selects code 1 (1.00 % down).
- R7: With `sw_mode`=1, the code is taken from `sw_code`.
- R8: While the accepted enable is 0, `ofs_o` is exactly 0 for the whole period and `ofs_vld` stays high.
- R9: Code, mode and enable are sampled only on the clock where the phase is zero. A change made mid-period has no effect until the next period.
- R10: Power-down:
  - `pd_n` passes through a two-stage synchronizer.
  - From the third clock edge after `pd_n` falls, `ofs_vld` is 0 and `ofs_o` is 0.
  - After release, the sweep restarts at count 1 of a new period.
- R11: While `rst_n` is low, `ofs_o` is 0 and `ofs_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; straps are sampled while it is low |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| strap_i | input | 2 | Configuration straps |
| sw_mode | input | 1 | 1 selects the software code, 0 the strap-derived code |
| sw_code | input | 5 | Software spread code |
| spread_en | input | 1 | Spreading enable |
| strap_rb | output | 2 | Latched strap readback |
| ofs_o | output | OFS_W | Signed frequency offset, units of 1/HALF part per 10,000 |
| ofs_vld | output | 1 | High on every clock the sweep is running |

## Verification
A configuration reload and a power-down can fall on the same clock: the synchronized power-down can land exactly on the phase-zero clock, or a code change can arrive while the sweep is frozen. The bench provokes this by dropping `pd_n` at a chosen phase and changing codes at arbitrary phases. It then judges every output word against a cycle-accurate model of the synchronizer and period counter. The model shows that a frozen sweep resumes from count 1 with the configuration present at restart, and that a mid-period change surfaces only at the next zero crossing.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

  localparam int CODE_W  = 5;
  localparam int MAG_W   = 9;
  localparam int MAG_MAX = 300;

  typedef struct packed {
    logic             center;
    logic [MAG_W-1:0] mag;
  } ssc_cfg_t;

  // depth in parts per 10,000 and sweep style for one spread code
  function automatic ssc_cfg_t ssc_decode(input logic [CODE_W-1:0] code);
    ssc_cfg_t c;
    c.center = ((code >= 5'd7) && (code <= 5'd11)) || (code >= 5'd24);
    case (code)
      5'd0, 5'd16:           c.mag = 9'd80;
      5'd1, 5'd13, 5'd17:    c.mag = 9'd100;
      5'd2, 5'd12, 5'd18:    c.mag = 9'd125;
      5'd3, 5'd14, 5'd19:    c.mag = 9'd150;
      5'd4, 5'd20:           c.mag = 9'd175;
      5'd5, 5'd15, 5'd21:    c.mag = 9'd200;
      5'd6, 5'd22:           c.mag = 9'd250;
      5'd23:                 c.mag = 9'd300;
      5'd7, 5'd27:           c.mag = 9'd60;
      5'd8, 5'd29:           c.mag = 9'd100;
      5'd9, 5'd30:           c.mag = 9'd125;
      5'd10, 5'd31:          c.mag = 9'd150;
      5'd11:                 c.mag = 9'd200;
      5'd24:                 c.mag = 9'd30;
      5'd25:                 c.mag = 9'd40;
      5'd26:                 c.mag = 9'd50;
      default:               c.mag = 9'd80;   // code 28
    endcase
    return c;
  endfunction

  // strap pair to spread code: 11 -> center 1.00, else down 1.00
  function automatic logic [CODE_W-1:0] ssc_strap_code(input logic [1:0] s);
    return (s == 2'b11) ? 5'd8 : 5'd1;
  endfunction

endpackage

// File: rtl/ssc_pd_sync.sv
module ssc_pd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES:0] tap;
  assign tap[0] = async_i;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= tap[i];
    end
    assign tap[i+1] = q;
  end

  assign sync_o = tap[STAGES];

endmodule

// File: rtl/ssc_src_sel.sv
module ssc_src_sel
  import ssc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        strap_i,
  input  logic              sw_mode,
  input  logic [CODE_W-1:0] sw_code,
  input  logic              spread_en,
  output logic [1:0]        strap_q,
  output ssc_cfg_t          cfg_live,
  output logic              en_live
);

  logic [CODE_W-1:0] code_sel;

  // straps follow the pins only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_i;
  end

  assign code_sel = sw_mode ? sw_code : ssc_strap_code(strap_q);
  assign cfg_live = ssc_decode(code_sel);
  assign en_live  = spread_en;

endmodule

// File: rtl/ssc_sweep.sv
module ssc_sweep
  import ssc_pkg::*;
#(
  parameter int PERIOD = 6400,
  parameter int OFS_W  = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  ssc_cfg_t                cfg_live,
  input  logic                    en_live,
  output logic signed [OFS_W-1:0] ofs_o,
  output logic                    vld_o,
  output logic                    cfg_load,
  output logic                    act_center
);

  localparam int PH_W = $clog2(PERIOD);
  localparam logic [PH_W-1:0] LAST_P = PH_W'(PERIOD - 1);
  localparam logic [PH_W-1:0] HALF_P = PH_W'(PERIOD / 2);
  localparam logic [PH_W-1:0] QTR_P  = PH_W'(PERIOD / 4);
  localparam logic [PH_W-1:0] TQ_P   = PH_W'((3 * PERIOD) / 4);

  logic [PH_W-1:0]         ph_q;
  ssc_cfg_t                cfg_q;
  logic                    en_q;
  ssc_cfg_t                cfg_use;
  logic                    en_use;
  logic signed [OFS_W-1:0] step;

  // signed increment for the current phase of the triangle
  function automatic logic signed [OFS_W-1:0] step_of(input ssc_cfg_t c,
                                                      input logic [PH_W-1:0] ph);
    logic signed [OFS_W-1:0] m;
    m = $signed({{(OFS_W-MAG_W){1'b0}}, c.mag});
    if (c.center) begin
      m = m <<< 1;
      return ((ph < QTR_P) || (ph >= TQ_P)) ? m : -m;
    end
    return (ph < HALF_P) ? -m : m;
  endfunction

  assign cfg_load   = run && (ph_q == '0);
  assign cfg_use    = cfg_load ? cfg_live : cfg_q;
  assign en_use     = cfg_load ? en_live  : en_q;
  assign step       = step_of(cfg_use, ph_q);
  assign act_center = cfg_q.center;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      cfg_q <= '0;
      en_q  <= 1'b0;
      ofs_o <= '0;
      vld_o <= 1'b0;
    end else if (!run) begin
      ph_q  <= '0;
      en_q  <= 1'b0;
      ofs_o <= '0;
      vld_o <= 1'b0;
    end else begin
      if (cfg_load) begin
        cfg_q <= cfg_live;
        en_q  <= en_live;
      end
      ph_q  <= (ph_q == LAST_P) ? '0 : ph_q + PH_W'(1);
      ofs_o <= en_use ? ofs_o + step : '0;
      vld_o <= 1'b1;
    end
  end

endmodule

// File: rtl/ssc_profile_ctl.sv
module ssc_profile_ctl
  import ssc_pkg::*;
#(
  parameter int CLK_HZ      = 200_000_000,
  parameter int MOD_HZ      = 31_250,
  parameter int OFS_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pd_n,
  input  logic [1:0]              strap_i,
  input  logic                    sw_mode,
  input  logic [4:0]              sw_code,
  input  logic                    spread_en,
  output logic [1:0]              strap_rb,
  output logic signed [OFS_W-1:0] ofs_o,
  output logic                    ofs_vld
);

  localparam int PERIOD = CLK_HZ / MOD_HZ;
  localparam int HALF   = PERIOD / 2;

  logic     run;
  logic     cfg_load;
  logic     act_center;
  logic     en_live;
  ssc_cfg_t cfg_live;

  ssc_pd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pd_n),
    .sync_o  (run)
  );

  ssc_src_sel u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_i   (strap_i),
    .sw_mode   (sw_mode),
    .sw_code   (sw_code),
    .spread_en (spread_en),
    .strap_q   (strap_rb),
    .cfg_live  (cfg_live),
    .en_live   (en_live)
  );

  ssc_sweep #(.PERIOD(PERIOD), .OFS_W(OFS_W)) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .cfg_live   (cfg_live),
    .en_live    (en_live),
    .ofs_o      (ofs_o),
    .vld_o      (ofs_vld),
    .cfg_load   (cfg_load),
    .act_center (act_center)
  );

endmodule

// File: rtl/ssc_profile_chk.sv
module ssc_profile_chk
  import ssc_pkg::*;
#(
  parameter int OFS_W = 24,
  parameter int HALF  = 3200
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    run,
  input logic                    ofs_vld,
  input logic signed [OFS_W-1:0] ofs_o,
  input logic                    cfg_load,
  input logic                    act_center,
  input logic                    en_live,
  input logic [1:0]              strap_rb
);

  localparam logic signed [OFS_W:0] LIM  = (OFS_W+1)'(MAG_MAX * HALF);
  localparam logic signed [OFS_W:0] STEP = (OFS_W+1)'(2 * MAG_MAX);

  logic signed [OFS_W-1:0] prev_q;
  logic signed [OFS_W:0]   cur_x;
  logic signed [OFS_W:0]   diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= ofs_o;
  end

  assign cur_x = {ofs_o[OFS_W-1], ofs_o};
  assign diff  = cur_x - {prev_q[OFS_W-1], prev_q};

  AST_DOWN_NONPOS: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_vld && !act_center) |-> (ofs_o <= 0));  // R1

  AST_PEAK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ofs_vld |-> ((cur_x <= LIM) && (cur_x >= -LIM)));  // R2

  AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_vld && $past(ofs_vld)) |-> ((diff <= STEP) && (diff >= -STEP)));  // R3

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_rb));  // R5

  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !en_live) |=> (ofs_o == 0));  // R8

  AST_LOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> (ofs_o == 0));  // R9

  AST_PD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!ofs_vld && ofs_o == 0));  // R10

endmodule

bind ssc_profile_ctl ssc_profile_chk #(.OFS_W(OFS_W), .HALF(HALF)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .ofs_vld    (ofs_vld),
  .ofs_o      (ofs_o),
  .cfg_load   (cfg_load),
  .act_center (act_center),
  .en_live    (en_live),
  .strap_rb   (strap_rb)
);

// File: tb/sim_ssc_profile_ctl.sv
`timescale 1ns/1ps
module sim_ssc_profile_ctl;

  localparam int CLK_HZ = 2_560_000;
  localparam int MOD_HZ = 32_000;
  localparam int P  = CLK_HZ / MOD_HZ;
  localparam int H  = P / 2;
  localparam int Q  = P / 4;
  localparam int OW = 24;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 rst_n, pd_n, sw_mode, spread_en;
  logic [1:0]           strap_i;
  logic [4:0]           sw_code;
  logic [1:0]           strap_rb;
  logic signed [OW-1:0] ofs_o;
  logic                 ofs_vld;

  ssc_profile_ctl #(.CLK_HZ(CLK_HZ), .MOD_HZ(MOD_HZ), .OFS_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .strap_i(strap_i),
    .sw_mode(sw_mode), .sw_code(sw_code), .spread_en(spread_en),
    .strap_rb(strap_rb), .ofs_o(ofs_o), .ofs_vld(ofs_vld)
  );

  int total = 0;
  int bad   = 0;

  typedef struct { bit vld; int ofs; string tag; } exp_t;
  exp_t sbq[$];
  exp_t e_pop, e_push;

  // bench model state
  bit m_s1 = 0, m_s2 = 0, m_cen = 0, m_en = 0, m_sw = 0, r9_mark = 0;
  int m_ph = 0, m_mag = 0, m_strap = 0;
  int obs_min = 0, obs_max = 0, lp_min = 0, lp_max = 0;

  int dn_a[7] = '{80, 100, 125, 150, 175, 200, 250};
  int dn_b[4] = '{125, 100, 150, 200};
  int dn_c[8] = '{80, 100, 125, 150, 175, 200, 250, 300};
  int ce_a[5] = '{60, 100, 125, 150, 200};
  int ce_b[8] = '{30, 40, 50, 60, 80, 100, 125, 150};

  function automatic bit is_center(int code);
    return (code >= 7 && code <= 11) || code >= 24;
  endfunction

  function automatic int depth_of(int code);
    if (code <= 6)  return dn_a[code];
    if (code <= 11) return ce_a[code-7];
    if (code <= 15) return dn_b[code-12];
    if (code <= 23) return dn_c[code-16];
    return ce_b[code-24];
  endfunction

  function automatic int shape(bit cen, int d, int n);
    if (!cen) return (n <= H) ? -d*n : -d*(P-n);
    if (n <= Q)   return 2*d*n;
    if (n <= 3*Q) return 2*d*(2*Q-n);
    return 2*d*(n-P);
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // prediction for the outputs after the coming rising edge
  task predict;
    int n, code;
    e_push.vld = 0; e_push.ofs = 0;
    if (!rst_n) begin
      e_push.tag = "R11";
      m_s1 = 0; m_s2 = 0; m_ph = 0; m_strap = strap_i;
    end else if (!m_s2) begin
      e_push.tag = "R10";
      m_ph = 0; m_s2 = m_s1; m_s1 = pd_n;
    end else begin
      if (m_ph == 0) begin
        code  = sw_mode ? int'(sw_code) : ((m_strap == 3) ? 8 : 1);
        m_cen = is_center(code);
        m_mag = depth_of(code);
        m_en  = spread_en;
        m_sw  = sw_mode;
        lp_min = obs_min; lp_max = obs_max;
        obs_min = 0; obs_max = 0;
        r9_mark = 0;
      end
      n = m_ph + 1;
      e_push.vld = 1;
      e_push.ofs = m_en ? shape(m_cen, m_mag, n) : 0;
      if (!m_en)        e_push.tag = "R8";
      else if (r9_mark) e_push.tag = "R9";
      else if (n == P)  e_push.tag = "R4";
      else if (n == 1)  e_push.tag = "R3";
      else if (!m_sw)   e_push.tag = "R6";
      else              e_push.tag = m_cen ? "R2 R7" : "R1 R7";
      m_ph = n % P;
      m_s2 = m_s1; m_s1 = pd_n;
    end
    sbq.push_back(e_push);
  endtask

  // monitor: compare the previous prediction, then predict the next edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      e_pop = sbq.pop_front();
      chk({e_pop.tag, " vld"}, int'(ofs_vld), int'(e_pop.vld));
      chk({e_pop.tag, " ofs"}, int'(ofs_o), e_pop.ofs);
      if (ofs_vld) begin
        if (int'(ofs_o) < obs_min) obs_min = int'(ofs_o);
        if (int'(ofs_o) > obs_max) obs_max = int'(ofs_o);
      end
    end
    predict();
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_ph(int k);
    do tick(1); while (m_ph != k);
  endtask

  task automatic check_period(string tag, int emin, int emax);
    chk({tag, " min"}, lp_min, emin);
    chk({tag, " max"}, lp_max, emax);
  endtask

  task automatic report;
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 0; pd_n = 1; strap_i = 2'b11; sw_mode = 0; sw_code = 0; spread_en = 1;
    tick(4);
    chk("R11 vld", int'(ofs_vld), 0);
    chk("R11 ofs", int'(ofs_o), 0);
    chk("R5 readback", int'(strap_rb), 3);
    rst_n = 1;
    tick(2*P + 6);
    check_period("R6 center", -100*H, 100*H);

    strap_i = 2'b00;                     // ignored after reset
    tick(5);
    chk("R5 hold", int'(strap_rb), 3);

    sw_mode = 1; sw_code = 5'd23;
    tick(2*P + 2);
    check_period("R1 R7 3.00", -300*H, 0);
    sw_code = 5'd24;
    tick(2*P + 2);
    check_period("R2 0.30", -30*H, 30*H);
    sw_code = 5'd12;
    tick(2*P + 2);
    check_period("R1 1.25", -125*H, 0);
    sw_code = 5'd7;
    tick(2*P + 2);
    check_period("R2 0.60", -60*H, 60*H);

    wait_ph(H);                          // mid-period change
    sw_code = 5'd16; r9_mark = 1;
    tick(3);
    check_period("R9 old period", -60*H, 60*H);
    tick(2*P);
    check_period("R9 new period", -80*H, 0);

    spread_en = 0;
    tick(2*P + 2);
    check_period("R8 off", 0, 0);

    spread_en = 1; sw_code = 5'd31;
    tick(P + 2);
    wait_ph(30);
    pd_n = 0;
    tick(4);
    chk("R10 vld", int'(ofs_vld), 0);
    chk("R10 ofs", int'(ofs_o), 0);
    tick(10);
    pd_n = 1;
    tick(2*P + 6);
    check_period("R10 resume", -150*H, 150*H);

    pd_n = 0;
    tick(5);
    rst_n = 0; strap_i = 2'b01; sw_mode = 0;
    tick(4);
    chk("R5 relatch", int'(strap_rb), 1);
    rst_n = 1; pd_n = 1;
    tick(2*P + 6);
    check_period("R6 down", -100*H, 0);

    tick(2);
    report();
    $finish;
  end

endmodule